// File: doc/BRIEF.md
# Filtered Tamper Input Detector

This block watches a single external tamper pin and reports a security event once the pin has held its active level for long enough. The pin is first brought into the clock domain through a two-flop synchronizer. It is then sampled on a slow filter tick. The filter tick is divided from one base tick enable, at one of four selectable rates. A duration counter accepts an event only after a programmed number of consecutive active samples. A single inactive sample sends the count back to zero, so short glitches and contact bounce are rejected.

When an event is accepted and no earlier event is pending, the block does three things:
- It sets a sticky status flag.
- It latches the current value of an external seconds counter as a timestamp.
- It raises the interrupt line.

Further detections are locked out until software acknowledges the event by writing a one to the status flag. Detection is level-based. A pin that is still held active after the acknowledge raises a new event on the next filter tick.

Top module: `tamper_guard`

## Requirements
- R1: After reset, `sts_flag`, `irq` and `stamp` are all zero.
- R2: With `cfg_pol`=1 a high pin is active, and with `cfg_pol`=0 a low pin is active. A pin held at the inactive level never produces an event.
- R3: The filter tick is a `base_tick` pulse that also ends a prescaler period. The period is selected by `cfg_clk_sel`: 0 gives every base tick, 1 every 4th, 2 every 8th and 3 every 32nd. With a 512 Hz base tick these are 512, 128, 64 and 16 Hz. The prescaler counts base ticks from reset.
- R4: An event is accepted on the filter tick that completes `cfg_dur` consecutive active samples. If the pin stays active beyond that, every later filter tick also counts as a detection.
- R5: A filter tick that samples the inactive level restarts the consecutive count from zero.
- R6: With `cfg_dur`=0, a single active sample on a filter tick is accepted.
- R7: While `sts_flag` is set, further detections change neither `sts_flag` nor `stamp`.
- R8: A cycle with `sts_wr`=1 and `sts_wdata`=1 clears `sts_flag` on the next edge. A write with `sts_wdata`=0 has no effect.
- R9: `irq` equals `sts_flag` at all times.
- R10: An accepted event sets `sts_flag` and loads `stamp` with the `seconds_in` value present in the cycle of detection. The two outputs change on the same edge.
- R11: If the pin is still active and past the filter when the status is cleared, a new event is stored on the next filter tick.
- R12: A change of `cfg_pol` or `cfg_dur` resets the consecutive count. A filter tick in the cycle of the change does not detect.
- R13: A pin change reaches the filter after two clock edges of synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle enable at the base filter rate |
| tamper_pin | input | 1 | Raw external tamper input |
| cfg_pol | input | 1 | 1 = active high, 0 = active low |
| cfg_clk_sel | input | 2 | Filter tick divider select |
| cfg_dur | input | 4 | Required consecutive active samples |
| seconds_in | input | 32 | Running seconds count to timestamp |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 1 | Write data for status bit (1 clears) |
| sts_flag | output | 1 | Sticky tamper status |
| irq | output | 1 | Tamper interrupt |
| stamp | output | 32 | Seconds value at the stored event |

## Verification
The assertions assume three things about the inputs:
- `sts_wr` and `sts_wdata` are sampled only on clock edges.
- `seconds_in` is a plain data value that may change on any cycle.
- The configuration inputs change only at cycle boundaries.

The stimulus drives every input on the falling edge and holds it through the following rising edge, so no input moves near the sampling edge. The stimulus covers the following:
- glitch runs shorter than the programmed duration;
- acknowledge writes while the pin is still held active;
- polarity and duration changes that land on filter ticks;
- a long pseudo-random pin sequence.

All of it is compared each cycle against a behavioural model.

// File: rtl/tamper_guard.sv
module tamper_guard #(
  parameter int TS_W  = 32,
  parameter int DUR_W = 4,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             tamper_pin,
  input  logic             cfg_pol,
  input  logic [1:0]       cfg_clk_sel,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic [TS_W-1:0]  seconds_in,
  input  logic             sts_wr,
  input  logic             sts_wdata,
  output logic             sts_flag,
  output logic             irq,
  output logic [TS_W-1:0]  stamp
);
  localparam logic [DUR_W-1:0] CNT_MAX = '1;

  logic             sync_a, sync_b;
  logic [PRE_W-1:0] pre;
  logic [DUR_W-1:0] run_cnt, dur_q;
  logic             pol_q;
  logic             period_end, ftick, active, cfg_chg, hit, ack;

  assign active  = cfg_pol ? sync_b : ~sync_b;
  assign cfg_chg = (cfg_pol != pol_q) || (cfg_dur != dur_q);
  assign ftick   = base_tick & period_end;
  assign hit     = ftick & active & ~cfg_chg &
                   (({1'b0, run_cnt} + 1'b1) >= {1'b0, cfg_dur});
  assign ack     = sts_wr & sts_wdata;
  assign irq     = sts_flag;

  always_comb begin
    case (cfg_clk_sel)
      2'd0:    period_end = 1'b1;
      2'd1:    period_end = &pre[1:0];
      2'd2:    period_end = &pre[2:0];
      default: period_end = &pre;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= tamper_pin;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre <= '0;
    else if (base_tick) pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      pol_q   <= 1'b0;
      dur_q   <= '0;
    end else begin
      pol_q <= cfg_pol;
      dur_q <= cfg_dur;
      if (cfg_chg)                run_cnt <= '0;
      else if (ftick && !active)  run_cnt <= '0;
      else if (ftick && run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_flag <= 1'b0;
      stamp    <= '0;
    end else if (sts_flag) begin
      if (ack) sts_flag <= 1'b0;
    end else if (hit) begin
      sts_flag <= 1'b1;
      stamp    <= seconds_in;
    end
  end
endmodule

module tamper_guard_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sts_wr,
  input logic            sts_wdata,
  input logic [TS_W-1:0] seconds_in,
  input logic            sts_flag,
  input logic            irq,
  input logic [TS_W-1:0] stamp
);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == sts_flag);

  p_stamp_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_flag |=> $stable(stamp));

  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flag && sts_wr && sts_wdata) |=> !sts_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flag && !(sts_wr && sts_wdata)) |=> sts_flag);

  p_stamp_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_flag) |=> (sts_flag ? (stamp == $past(seconds_in)) : $stable(stamp)));
endmodule

bind tamper_guard tamper_guard_chk #(.TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
  .seconds_in(seconds_in), .sts_flag(sts_flag), .irq(irq), .stamp(stamp)
);

// File: tb/tamper_guard_tb.sv
module tamper_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        tamper_pin = 1'b0;
  logic        cfg_pol = 1'b1;
  logic [1:0]  cfg_clk_sel = 2'd0;
  logic [3:0]  cfg_dur = 4'd3;
  logic [31:0] seconds_in = 32'h100;
  logic        sts_wr = 1'b0;
  logic        sts_wdata = 1'b0;
  logic        sts_flag, irq;
  logic [31:0] stamp;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int m_s1, m_s2, m_pre, m_cnt, m_pol_q, m_dur_q, m_sts;
  longint m_stamp;

  always #10 clk = ~clk;

  tamper_guard dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .tamper_pin(tamper_pin),
    .cfg_pol(cfg_pol), .cfg_clk_sel(cfg_clk_sel), .cfg_dur(cfg_dur),
    .seconds_in(seconds_in), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .sts_flag(sts_flag), .irq(irq), .stamp(stamp)
  );

  function automatic void model_reset();
    m_s1 = 0; m_s2 = 0; m_pre = 0; m_cnt = 0;
    m_pol_q = 0; m_dur_q = 0; m_sts = 0; m_stamp = 0;
  endfunction

  function automatic void model_advance();
    int divs[4] = '{1, 4, 8, 32};
    int  div    = divs[cfg_clk_sel];
    bit  act    = cfg_pol ? (m_s2 == 1) : (m_s2 == 0);
    bit  chg    = (int'(cfg_pol) != m_pol_q) || (int'(cfg_dur) != m_dur_q);
    bit  tick   = base_tick && ((m_pre % div) == div - 1);
    bit  hit    = tick && act && !chg && (m_cnt + 1 >= int'(cfg_dur));
    if (m_sts == 1) begin
      if (sts_wr && sts_wdata) m_sts = 0;
    end else if (hit) begin
      m_sts = 1;
      m_stamp = seconds_in;
    end
    if (chg) m_cnt = 0;
    else if (tick) m_cnt = act ? ((m_cnt < 15) ? m_cnt + 1 : 15) : 0;
    if (base_tick) m_pre = (m_pre + 1) % 32;
    m_pol_q = cfg_pol;
    m_dur_q = cfg_dur;
    m_s2 = m_s1;
    m_s1 = tamper_pin;
  endfunction

  task automatic compare(input string req);
    vectors++;
    if (sts_flag !== m_sts[0] || irq !== m_sts[0] || stamp !== m_stamp[31:0]) begin
      errors++;
      $display("FAIL %s t=%0t sts=%0b irq=%0b stamp=%0h expected sts=%0b irq=%0b stamp=%0h",
               req, $time, sts_flag, irq, stamp, m_sts[0], m_sts[0], m_stamp[31:0]);
    end
  endtask

  task automatic step(input string req);
    model_advance();
    @(posedge clk);
    @(negedge clk);
    compare(req);
    seconds_in = seconds_in + 1;
  endtask

  task automatic steps(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic ack(input bit data, input string req);
    sts_wr = 1'b1;
    sts_wdata = data;
    step(req);
    sts_wr = 1'b0;
    sts_wdata = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    base_tick = 1'b1;

    // R13 R4 R10: active-high run on every base tick
    steps(2, "R13 idle");
    tamper_pin = 1'b1;
    steps(6, "R4 R10 R13 detect");
    // R7: held active, status locked
    steps(6, "R7 lockout");
    // R8: writing zero has no effect
    ack(1'b0, "R8 write zero");
    step("R8 still set");
    // R11: clear while still active retriggers
    ack(1'b1, "R8 R11 clear");
    steps(3, "R11 retrigger");

    // R5: glitches shorter than duration
    tamper_pin = 1'b0;
    steps(3, "R5 settle");
    ack(1'b1, "R8 clear");
    for (int k = 0; k < 4; k++) begin
      tamper_pin = 1'b1; steps(2, "R5 glitch hi");
      tamper_pin = 1'b0; steps(1, "R5 glitch lo");
    end
    steps(3, "R5 no event");

    // R2 R12: switch to active low, pin low
    cfg_pol = 1'b0;
    steps(6, "R2 R12 active low");
    tamper_pin = 1'b1;
    steps(3, "R2 inactive");
    ack(1'b1, "R8 clear");
    steps(8, "R2 high ignored when active low");

    // R12: duration change restarts count
    tamper_pin = 1'b0;
    cfg_dur = 4'd6;
    steps(4, "R12 partial");
    cfg_dur = 4'd5;
    steps(3, "R12 restart");
    steps(4, "R12 complete");
    tamper_pin = 1'b1;
    steps(3, "R12 settle");
    ack(1'b1, "R8 clear");

    // R6 R3: duration zero, slowest clock
    cfg_pol = 1'b1;
    cfg_dur = 4'd0;
    cfg_clk_sel = 2'd3;
    tamper_pin = 1'b0;
    steps(4, "R6 idle");
    tamper_pin = 1'b1;
    steps(40, "R3 R6 sel3");
    tamper_pin = 1'b0;
    ack(1'b1, "R8 clear");

    // R3: other divisions with sparse base ticks
    for (int s = 1; s < 3; s++) begin
      cfg_clk_sel = s[1:0];
      cfg_dur = 4'd2;
      steps(4, "R3 sel");
      tamper_pin = 1'b1;
      for (int c = 0; c < 40; c++) begin
        base_tick = (c % 2) == 0;
        step("R3 divided tick");
      end
      base_tick = 1'b1;
      tamper_pin = 1'b0;
      steps(3, "R3 settle");
      ack(1'b1, "R8 clear");
    end

    // mixed pseudo-random traffic
    for (int r = 0; r < 3000; r++) begin
      tamper_pin = ($urandom % 5) != 0;
      base_tick = ($urandom % 3) != 0;
      if (($urandom % 40) == 0) cfg_pol = ~cfg_pol;
      if (($urandom % 60) == 0) cfg_dur = 4'($urandom % 5);
      if (($urandom % 80) == 0) cfg_clk_sel = 2'($urandom % 4);
      sts_wr = ($urandom % 10) == 0;
      sts_wdata = ($urandom % 2) == 0;
      step("R2 R4 R5 R7 R8 R11 R12 random");
    end
    sts_wr = 1'b0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule